// File: doc/BRIEF.md
# Pluggable Optical Port Supervisor

This block sits on the host side of one hot-pluggable optical transceiver cage. It watches three lines coming from the module, already brought into the local clock domain: the presence line, the transmitter fault line and the receive loss-of-signal line. It drives the module's transmit-disable line. It reports a three-bit port status code, and it raises a one-cycle interrupt pulse each time that code changes.

An insertion is accepted only after the presence line has held steady for a debounce window. The block then enables the transmitter and waits out the module's initialization window. During that window the fault line is ignored. Loss-of-signal is accepted only after it has persisted for its own window. A transmitter fault starts an automatic recovery. Each recovery attempt drives the disable line high for a reset time, releases it, and then waits another initialization window before the fault line is checked again. The number of attempts is bounded. When the attempts run out, the port is latched in a failed state that only software can clear. A confirmed removal abandons whatever is in progress and returns the port to the absent state with the transmitter disabled.

All windows are given as clock-cycle counts through parameters.

Top module: `port_supervisor`

## Requirements
- R1: During and right after reset, statusCode is 0 (absent), txDisable is 1 and statusIrq is 0.
- R2: A low presentN means a module is present. A change of presentN is accepted only after it has held for DEBOUNCE_CYC cycles. A change that reverts sooner has no effect on statusCode.
- R3: A confirmed insertion moves the port to code 1 (initializing) with txDisable low. For INIT_CYC cycles in that state, a high faultIn has no effect.
- R4: At the end of initialization, with faultIn low, the port moves to code 2 (ready) if the qualified loss-of-signal is low, or to code 3 (no-signal) if it is high. In code 2, txDisable is low.
- R5: A high losIn means no signal. A change of losIn is accepted only after it has held for LOS_CYC cycles. Ready and no-signal follow the accepted value, and shorter pulses have no effect.
- R6: A high faultIn in ready or no-signal, or at the end of initialization, moves the port to code 4 (recovering). In code 4, txDisable is high for RESET_CYC cycles and then low for a full INIT_CYC window, after which faultIn is sampled again.
- R7: If faultIn is still high after MAX_RETRY disable pulses, the port enters code 5 (failed) with txDisable high. It stays there through removal and insertion until swClear is high for a cycle. swClear then moves it to code 1 if a module is present, and to code 0 otherwise.
- R8: A confirmed removal in any state other than failed moves the port to code 0 with txDisable high, and any recovery in progress is abandoned.
- R9: statusIrq is high for exactly one cycle, in the same cycle that statusCode takes a new value, and never in any other cycle.
- R10: Reaching ready or no-signal without a fault resets the retry count, so every new fault episode gets the full MAX_RETRY attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| presentN | input | 1 | Module presence, low when inserted (synchronized) |
| faultIn | input | 1 | Transmitter fault from the module, high when asserted (synchronized) |
| losIn | input | 1 | Receive loss-of-signal, high when asserted (synchronized) |
| swClear | input | 1 | Software clear of the latched failed state |
| txDisable | output | 1 | Transmit disable to the module, high disables |
| statusCode | output | 3 | Port status: 0 absent, 1 initializing, 2 ready, 3 no-signal, 4 recovering, 5 failed |
| statusIrq | output | 1 | One-cycle pulse on every status change |

## Verification
The assertions take for granted that presentN, faultIn and losIn are already synchronous to clk. They also assume reset is held across the first few clock edges, so that every history term starts from reset values. The debounce and persistence checks further assume that every window parameter is at least one cycle. The bench changes its inputs only on falling clock edges, holds reset for several cycles before any activity, and uses short windows. Its long holds and its deliberately short glitches therefore both fall clearly on one side of each window boundary.

// File: rtl/port_sup_pkg.sv
package port_sup_pkg;

  typedef enum logic [2:0] {
    PC_ABSENT  = 3'd0,
    PC_INIT    = 3'd1,
    PC_READY   = 3'd2,
    PC_NOSIG   = 3'd3,
    PC_RECOVER = 3'd4,
    PC_FAILED  = 3'd5
  } portCode_e;

  typedef enum logic [2:0] {
    ST_ABSENT,
    ST_INIT,
    ST_READY,
    ST_NOSIG,
    ST_PULSE,
    ST_WAIT,
    ST_FAILED
  } supState_e;

  typedef struct packed {
    logic loadInit;
    logic loadPulse;
    logic retryInc;
    logic retryClr;
  } dpStrobe_t;

endpackage

// File: rtl/port_sup_datapath.sv
module port_sup_datapath
  import port_sup_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 250000,
  parameter int INIT_CYC     = 75000000,
  parameter int LOS_CYC      = 25000,
  parameter int RESET_CYC    = 2500,
  parameter int MAX_RETRY    = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      presentN,
  input  logic      losIn,
  input  dpStrobe_t stb,
  output logic      presStable,
  output logic      losQual,
  output logic      tmrDone,
  output logic      retryMax
);

  localparam int TMR_MAX = (INIT_CYC > RESET_CYC) ? INIT_CYC : RESET_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int DEB_W   = $clog2(DEBOUNCE_CYC + 1);
  localparam int LOS_W   = (LOS_CYC > 1) ? $clog2(LOS_CYC + 1) : 1;
  localparam int RTY_W   = $clog2(MAX_RETRY + 2);

  // presence debounce: flip only after DEBOUNCE_CYC cycles of disagreement
  logic             presRaw;
  logic [DEB_W-1:0] debCnt;

  assign presRaw = ~presentN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presStable <= 1'b0;
      debCnt     <= '0;
    end else if (presRaw == presStable) begin
      debCnt <= '0;
    end else if (debCnt == DEB_W'(DEBOUNCE_CYC - 1)) begin
      presStable <= presRaw;
      debCnt     <= '0;
    end else begin
      debCnt <= debCnt + 1'b1;
    end
  end

  // loss-of-signal persistence filter
  generate
    if (LOS_CYC == 0) begin : g_losDirect
      always_ff @(posedge clk) begin
        if (!rstN) losQual <= 1'b1;
        else       losQual <= losIn;
      end
    end else begin : g_losFilter
      logic [LOS_W-1:0] losCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          losQual <= 1'b1;
          losCnt  <= '0;
        end else if (losIn == losQual) begin
          losCnt <= '0;
        end else if (losCnt == LOS_W'(LOS_CYC - 1)) begin
          losQual <= losIn;
          losCnt  <= '0;
        end else begin
          losCnt <= losCnt + 1'b1;
        end
      end
    end
  endgenerate

  // shared window timer
  logic [TMR_W-1:0] tmrCnt;

  always_ff @(posedge clk) begin
    if (!rstN)              tmrCnt <= '0;
    else if (stb.loadInit)  tmrCnt <= TMR_W'(INIT_CYC);
    else if (stb.loadPulse) tmrCnt <= TMR_W'(RESET_CYC);
    else if (tmrCnt != '0)  tmrCnt <= tmrCnt - 1'b1;
  end

  assign tmrDone = (tmrCnt == '0);

  // recovery attempt counter
  logic [RTY_W-1:0] retryCnt;

  always_ff @(posedge clk) begin
    if (!rstN)             retryCnt <= '0;
    else if (stb.retryClr) retryCnt <= '0;
    else if (stb.retryInc) retryCnt <= retryCnt + 1'b1;
  end

  assign retryMax = (retryCnt >= RTY_W'(MAX_RETRY));

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RTY_W'(MAX_RETRY)); // R7

  AST_DEB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (presStable != $past(presStable)) |-> ($past(presRaw) == presStable)); // R2

  AST_LOS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (losQual != $past(losQual)) |-> ($past(losIn) == losQual)); // R5

endmodule

// File: rtl/port_sup_control.sv
module port_sup_control
  import port_sup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      presStable,
  input  logic      losQual,
  input  logic      tmrDone,
  input  logic      retryMax,
  input  logic      faultIn,
  input  logic      swClear,
  output dpStrobe_t stb,
  output logic      txDisable,
  output logic [2:0] statusCode,
  output logic      statusIrq
);

  supState_e st, nxt;

  function automatic portCode_e codeOf(supState_e s);
    case (s)
      ST_ABSENT:         return PC_ABSENT;
      ST_INIT:           return PC_INIT;
      ST_READY:          return PC_READY;
      ST_NOSIG:          return PC_NOSIG;
      ST_PULSE, ST_WAIT: return PC_RECOVER;
      default:           return PC_FAILED;
    endcase
  endfunction

  always_comb begin
    nxt = st;
    stb = '0;
    unique case (st)
      ST_ABSENT: begin
        if (presStable) begin
          nxt          = ST_INIT;
          stb.loadInit = 1'b1;
          stb.retryClr = 1'b1;
        end
      end
      ST_INIT, ST_WAIT: begin
        if (!presStable) begin
          nxt = ST_ABSENT;
        end else if (tmrDone) begin
          if (faultIn) begin
            if (retryMax) nxt = ST_FAILED;
            else begin
              nxt           = ST_PULSE;
              stb.loadPulse = 1'b1;
              stb.retryInc  = 1'b1;
            end
          end else begin
            nxt          = losQual ? ST_NOSIG : ST_READY;
            stb.retryClr = 1'b1;
          end
        end
      end
      ST_READY, ST_NOSIG: begin
        if (!presStable) begin
          nxt = ST_ABSENT;
        end else if (faultIn) begin
          if (retryMax) nxt = ST_FAILED;
          else begin
            nxt           = ST_PULSE;
            stb.loadPulse = 1'b1;
            stb.retryInc  = 1'b1;
          end
        end else begin
          nxt = losQual ? ST_NOSIG : ST_READY;
        end
      end
      ST_PULSE: begin
        if (!presStable) begin
          nxt = ST_ABSENT;
        end else if (tmrDone) begin
          nxt          = ST_WAIT;
          stb.loadInit = 1'b1;
        end
      end
      default: begin
        if (swClear) begin
          if (presStable) begin
            nxt          = ST_INIT;
            stb.loadInit = 1'b1;
            stb.retryClr = 1'b1;
          end else begin
            nxt = ST_ABSENT;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_ABSENT;
      txDisable  <= 1'b1;
      statusCode <= PC_ABSENT;
      statusIrq  <= 1'b0;
    end else begin
      st         <= nxt;
      txDisable  <= (nxt == ST_ABSENT) || (nxt == ST_PULSE) || (nxt == ST_FAILED);
      statusCode <= codeOf(nxt);
      statusIrq  <= (codeOf(nxt) != codeOf(st));
    end
  end

  AST_FAIL_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_FAILED && !swClear) |=> (st == ST_FAILED)); // R7

  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_INIT && !tmrDone && presStable) |=> (st == ST_INIT)); // R3

  AST_ABSENT_DIS: assert property (@(posedge clk) disable iff (!rstN)
    (statusCode == PC_ABSENT) |-> txDisable); // R8

  AST_READY_EN: assert property (@(posedge clk) disable iff (!rstN)
    (statusCode == PC_READY) |-> !txDisable); // R4

  AST_IRQ_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    statusIrq |-> (statusCode != $past(statusCode))); // R9

  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (statusCode != $past(statusCode)) |-> statusIrq); // R9

endmodule

// File: rtl/port_supervisor.sv
module port_supervisor
  import port_sup_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 250000,
  parameter int INIT_CYC     = 75000000,
  parameter int LOS_CYC      = 25000,
  parameter int RESET_CYC    = 2500,
  parameter int MAX_RETRY    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       presentN,
  input  logic       faultIn,
  input  logic       losIn,
  input  logic       swClear,
  output logic       txDisable,
  output logic [2:0] statusCode,
  output logic       statusIrq
);

  dpStrobe_t stb;
  logic presStable, losQual, tmrDone, retryMax;

  port_sup_datapath #(
    .DEBOUNCE_CYC(DEBOUNCE_CYC),
    .INIT_CYC    (INIT_CYC),
    .LOS_CYC     (LOS_CYC),
    .RESET_CYC   (RESET_CYC),
    .MAX_RETRY   (MAX_RETRY)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .presentN  (presentN),
    .losIn     (losIn),
    .stb       (stb),
    .presStable(presStable),
    .losQual   (losQual),
    .tmrDone   (tmrDone),
    .retryMax  (retryMax)
  );

  port_sup_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .presStable(presStable),
    .losQual   (losQual),
    .tmrDone   (tmrDone),
    .retryMax  (retryMax),
    .faultIn   (faultIn),
    .swClear   (swClear),
    .stb       (stb),
    .txDisable (txDisable),
    .statusCode(statusCode),
    .statusIrq (statusIrq)
  );

endmodule

// File: tb/port_supervisor_tb_top.sv
module port_supervisor_tb_top;

  localparam int DEB = 8;
  localparam int INI = 40;
  localparam int LOS = 10;
  localparam int RST = 12;
  localparam int MAXR = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic presentN = 1'b1;
  logic faultIn = 1'b0;
  logic losIn = 1'b1;
  logic swClear = 1'b0;
  logic txDisable, statusIrq;
  logic [2:0] statusCode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  port_supervisor #(
    .DEBOUNCE_CYC(DEB), .INIT_CYC(INI), .LOS_CYC(LOS),
    .RESET_CYC(RST), .MAX_RETRY(MAXR)
  ) dut_i (
    .clk(clk), .rstN(rstN), .presentN(presentN), .faultIn(faultIn),
    .losIn(losIn), .swClear(swClear), .txDisable(txDisable),
    .statusCode(statusCode), .statusIrq(statusIrq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R9: interrupt must coincide with every code change and nothing else
  logic [2:0] prevCode = 3'd0;
  always @(negedge clk) begin
    if (rstN) begin
      if ((statusCode != prevCode) || statusIrq) begin
        checks++;
        if ((statusCode != prevCode) != statusIrq) begin
          errors++;
          $display("FAIL R9 irq actual=%0d expected=%0d", statusIrq, statusCode != prevCode);
        end
      end
      prevCode = statusCode;
    end
  end

  task automatic t_reset();
    cyc(5);
    chk("R1", "code", statusCode, 0);
    chk("R1", "txDisable", txDisable, 1);
    chk("R1", "irq", statusIrq, 0);
    rstN = 1'b1;
    cyc(2);
    chk("R1", "code after reset", statusCode, 0);
  endtask

  task automatic t_glitch();
    presentN = 1'b0;
    cyc(DEB - 3);
    presentN = 1'b1;
    cyc(20);
    chk("R2", "short presence glitch", statusCode, 0);
  endtask

  task automatic t_insert();
    losIn = 1'b0;
    presentN = 1'b0;
    cyc(DEB - 1);
    chk("R2", "before debounce", statusCode, 0);
    cyc(4);
    chk("R3", "initializing", statusCode, 1);
    chk("R3", "tx enabled", txDisable, 0);
    faultIn = 1'b1;
    cyc(INI - 15);
    chk("R3", "fault ignored", statusCode, 1);
    faultIn = 1'b0;
    cyc(20);
    chk("R4", "ready", statusCode, 2);
    chk("R4", "tx enabled ready", txDisable, 0);
  endtask

  task automatic t_los();
    losIn = 1'b1;
    cyc(LOS - 3);
    losIn = 1'b0;
    cyc(15);
    chk("R5", "short los pulse", statusCode, 2);
    losIn = 1'b1;
    cyc(LOS - 2);
    chk("R5", "los not yet", statusCode, 2);
    cyc(5);
    chk("R5", "no-signal", statusCode, 3);
    losIn = 1'b0;
    cyc(LOS + 3);
    chk("R5", "signal back", statusCode, 2);
  endtask

  task automatic t_recover();
    faultIn = 1'b1;
    cyc(2);
    chk("R6", "recovering", statusCode, 4);
    chk("R6", "pulse high", txDisable, 1);
    cyc(RST - 4);
    chk("R6", "pulse still high", txDisable, 1);
    cyc(6);
    chk("R6", "pulse released", txDisable, 0);
    chk("R6", "still recovering", statusCode, 4);
    faultIn = 1'b0;
    cyc(INI - 5);
    chk("R6", "waits full window", statusCode, 4);
    cyc(10);
    chk("R6", "recovered", statusCode, 2);
  endtask

  task automatic t_retryClear();
    for (int e = 0; e < 2; e++) begin
      faultIn = 1'b1;
      cyc(3);
      faultIn = 1'b0;
      cyc(RST + INI + 10);
      chk("R10", "episode recovered", statusCode, 2);
    end
    faultIn = 1'b1;
    cyc(3);
    chk("R10", "fresh retries", statusCode, 4);
    faultIn = 1'b0;
    cyc(RST + INI + 10);
    chk("R10", "third recovered", statusCode, 2);
  endtask

  task automatic t_fail();
    faultIn = 1'b1;
    cyc(2 * (RST + INI + 4) + 20);
    chk("R7", "failed", statusCode, 5);
    chk("R7", "tx disabled", txDisable, 1);
    faultIn = 1'b0;
    presentN = 1'b1;
    cyc(DEB + 5);
    chk("R7", "latched over removal", statusCode, 5);
    presentN = 1'b0;
    cyc(DEB + 5);
    chk("R7", "latched over insertion", statusCode, 5);
    swClear = 1'b1;
    cyc(1);
    swClear = 1'b0;
    cyc(1);
    chk("R7", "clear to init", statusCode, 1);
    cyc(INI + 5);
    chk("R7", "ready after clear", statusCode, 2);
  endtask

  task automatic t_remove();
    faultIn = 1'b1;
    cyc(3);
    chk("R8", "recovering before removal", statusCode, 4);
    presentN = 1'b1;
    cyc(DEB + 3);
    chk("R8", "absent", statusCode, 0);
    chk("R8", "tx disabled", txDisable, 1);
    faultIn = 1'b0;
    cyc(RST + INI);
    chk("R8", "recovery abandoned", statusCode, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_insert();
    t_los();
    t_recover();
    t_retryClear();
    t_fail();
    t_remove();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule